// File: doc/BRIEF.md
# Two-Master Bus Lock Arbiter

This block decides which of two upstream bus masters owns one shared downstream serial bus. Ownership is a lock that lasts across transactions. A master asks for the bus by raising its request line. It keeps the bus until it withdraws the request, is preempted by the other master once its reservation has run out, or loses it to the idle watchdog. The connection path to a master closes only while that master owns the lock and also asks to be connected.

Each master has several controls. It has a priority bit, which settles requests that arrive in the same cycle. It has an 8-bit reservation time in milliseconds, which protects a fresh owner from preemption. It has an idle-revocation enable, which takes the lock away once the reservation has expired and the downstream bus has stayed quiet for longer than a configured number of milliseconds (100 by default). Time comes from a one-cycle millisecond tick input. Downstream activity comes from a level input. One-cycle event pulses report each grant and each involuntary loss.

Top module: `dual_bus_lock_arbiter`

## Requirements
- R1: After reset no master is granted, both switch enables are 0, both peer flags are 0, and no event pulse is high.
- R2: A lone request from a master with the bus free makes `granted` for that master 1 one clock after the request is sampled. `grant_evt` for that master is high for exactly that first cycle of ownership.
- R3: `peer_locked[i]` is 1 exactly when the other master (index 1-i) is granted, and at most one master is granted at any time.
- R4: When both masters request in the same cycle with the bus free, master 1 wins only if its priority bit is 1 and master 0's is 0. In the other three priority combinations, master 0 wins.
- R5: `switch_en[i]` is 1 only when master i is granted and `connect[i]` is 1. A granted master with connect at 0 has its switch open, and a non-granted master never has its switch closed.
- R6: When the owner drops its request, its grant falls one clock later with no `lost_evt`. A request from the other master that was waiting is then granted on the following clock.
- R7: A write to a master's reservation value (`rsv_wr[i]` with bits [8i+7:8i] of `rsv_wdata`) has no effect while that master is granted. A write while it is not granted is stored and used on its next grant.
- R8: The reservation counter loads the owner's reservation value at grant and decrements on each `ms_tick` until it reaches 0. While it is nonzero, a request from the other master waits. On the clock after it reaches 0, a pending request from the other master takes the lock: `lost_evt` pulses for the old owner and `grant_evt` pulses for the new one.
- R9: A reservation value of 0 counts as already expired, so a pending request from the other master preempts on the clock after the grant.
- R10: With `idle_en` set for the owner, once the reservation has expired, IDLE_MS+1 ticks with `bus_active` low revoke the grant one clock after the last of those ticks. The revocation raises `lost_evt`. Any cycle with `bus_active` high restarts the count. With `idle_en` at 0, no revocation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_active | input | 1 | Downstream bus is busy this cycle |
| lock_req | input | 2 | Lock request per master |
| connect | input | 2 | Connect request per master |
| prio | input | 2 | Priority bit per master, for simultaneous requests |
| idle_en | input | 2 | Idle revocation enable per master |
| rsv_wr | input | 2 | Reservation value write strobe per master |
| rsv_wdata | input | 16 | Reservation values, master i in bits [8i+7:8i] |
| granted | output | 2 | Master owns the lock |
| peer_locked | output | 2 | The other master owns the lock |
| switch_en | output | 2 | Connection path closed for that master |
| grant_evt | output | 2 | Pulse on gaining the lock |
| lost_evt | output | 2 | Pulse on involuntary loss of the lock |

## Verification
The bench sweeps all four priority combinations for simultaneous requests. A design that favoured master 1 on a tie, or that read the priority bits backwards, would hand the lock to the wrong side. Reservation windows are tested one tick short of expiry and at expiry. An off-by-one in the countdown would preempt a tick early, or leave the other master waiting one cycle too long. A reservation write is made during ownership, and the bench then shows that a later grant still holds off a rival. A design that accepted the write would let the rival in at once. The idle watchdog is checked at its exact threshold, with a burst of bus activity that must restart the count, and with the enable off. Voluntary release is checked to raise no loss event.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_M0   = 2'd1,
        OWN_M1   = 2'd2
    } owner_e;

    // Owner code for a master index.
    function automatic owner_e owner_of(input logic idx);
        return idx ? OWN_M1 : OWN_M0;
    endfunction

    // Master index of an owner code (only meaningful when not OWN_NONE).
    function automatic logic owner_idx(input owner_e own);
        return (own == OWN_M1);
    endfunction

    // Simultaneous request resolution: master 1 wins only with strict priority.
    function automatic logic tie_winner(input logic [1:0] pr);
        return pr[1] & ~pr[0];
    endfunction

endpackage

// File: rtl/bus_lock_rsv_reg.sv
module bus_lock_rsv_reg #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [RES_W-1:0] wdata,
    input  logic             held,
    output logic [RES_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (wr && !held)
            value <= wdata;
    end
endmodule

// File: rtl/bus_lock_hold_timer.sv
module bus_lock_hold_timer #(
    parameter int RES_W   = 8,
    parameter int IDLE_MS = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  logic             held,
    input  logic             tick,
    input  logic             bus_busy,
    output logic             expired,
    output logic             idle_over
);
    localparam int IDLE_W = $clog2(IDLE_MS + 2);
    localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_MS + 1);

    logic [RES_W-1:0]  rsv_cnt;
    logic [IDLE_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_cnt  <= '0;
            idle_cnt <= '0;
        end else if (load) begin
            rsv_cnt  <= load_val;
            idle_cnt <= '0;
        end else if (!held) begin
            rsv_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            if (tick && rsv_cnt != '0)
                rsv_cnt <= rsv_cnt - 1'b1;
            if (bus_busy || rsv_cnt != '0)
                idle_cnt <= '0;
            else if (tick && idle_cnt != IDLE_LIM)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign expired   = (rsv_cnt == '0);
    assign idle_over = (idle_cnt == IDLE_LIM);
endmodule

// File: rtl/bus_lock_owner_arb.sv
module bus_lock_owner_arb
    import bus_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic [1:0] prio,
    input  logic [1:0] idle_en,
    input  logic       expired,
    input  logic       idle_over,
    output owner_e     owner,
    output owner_e     owner_nxt,
    output logic [1:0] grant_evt,
    output logic [1:0] lost_evt
);
    logic [1:0] gev_nxt;
    logic [1:0] lev_nxt;
    logic       cur;
    logic       oth;

    always_comb begin
        owner_nxt = owner;
        gev_nxt   = 2'b00;
        lev_nxt   = 2'b00;
        cur       = owner_idx(owner);
        oth       = ~cur;
        if (owner == OWN_NONE) begin
            if (req == 2'b11)
                owner_nxt = owner_of(tie_winner(prio));
            else if (req[0])
                owner_nxt = OWN_M0;
            else if (req[1])
                owner_nxt = OWN_M1;
        end else begin
            if (!req[cur]) begin
                owner_nxt = OWN_NONE;
            end else if (idle_over && idle_en[cur]) begin
                owner_nxt    = OWN_NONE;
                lev_nxt[cur] = 1'b1;
            end else if (req[oth] && expired) begin
                owner_nxt    = owner_of(oth);
                lev_nxt[cur] = 1'b1;
            end
        end
        if (owner_nxt != OWN_NONE && owner_nxt != owner)
            gev_nxt[owner_idx(owner_nxt)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner     <= OWN_NONE;
            grant_evt <= 2'b00;
            lost_evt  <= 2'b00;
        end else begin
            owner     <= owner_nxt;
            grant_evt <= gev_nxt;
            lost_evt  <= lev_nxt;
        end
    end
endmodule

// File: rtl/dual_bus_lock_arbiter.sv
module dual_bus_lock_arbiter
    import bus_lock_pkg::*;
#(
    parameter int RES_W   = 8,
    parameter int IDLE_MS = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ms_tick,
    input  logic               bus_active,
    input  logic [1:0]         lock_req,
    input  logic [1:0]         connect,
    input  logic [1:0]         prio,
    input  logic [1:0]         idle_en,
    input  logic [1:0]         rsv_wr,
    input  logic [2*RES_W-1:0] rsv_wdata,
    output logic [1:0]         granted,
    output logic [1:0]         peer_locked,
    output logic [1:0]         switch_en,
    output logic [1:0]         grant_evt,
    output logic [1:0]         lost_evt
);
    localparam int NM = 2;

    owner_e           owner;
    owner_e           owner_nxt;
    logic [RES_W-1:0] rsv_val [NM];
    logic             expired;
    logic             idle_over;
    logic             load;

    assign granted = {owner == OWN_M1, owner == OWN_M0};

    for (genvar i = 0; i < NM; i++) begin : g_master
        bus_lock_rsv_reg #(.RES_W(RES_W)) rsv_i (
            .clk   (clk),
            .rst   (rst),
            .wr    (rsv_wr[i]),
            .wdata (rsv_wdata[i*RES_W +: RES_W]),
            .held  (granted[i]),
            .value (rsv_val[i])
        );
        assign peer_locked[i] = granted[NM-1-i];
        assign switch_en[i]   = granted[i] & connect[i];
    end

    assign load = (owner_nxt != OWN_NONE) && (owner_nxt != owner);

    bus_lock_hold_timer #(.RES_W(RES_W), .IDLE_MS(IDLE_MS)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (rsv_val[owner_idx(owner_nxt)]),
        .held      (owner != OWN_NONE),
        .tick      (ms_tick),
        .bus_busy  (bus_active),
        .expired   (expired),
        .idle_over (idle_over)
    );

    bus_lock_owner_arb arb_i (
        .clk       (clk),
        .rst       (rst),
        .req       (lock_req),
        .prio      (prio),
        .idle_en   (idle_en),
        .expired   (expired),
        .idle_over (idle_over),
        .owner     (owner),
        .owner_nxt (owner_nxt),
        .grant_evt (grant_evt),
        .lost_evt  (lost_evt)
    );
endmodule

// File: rtl/dual_bus_lock_checker.sv
module dual_bus_lock_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lock_req,
    input logic [1:0] connect,
    input logic [1:0] granted,
    input logic [1:0] switch_en,
    input logic [1:0] grant_evt,
    input logic [1:0] lost_evt
);
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $countones(granted) <= 1); // R3

    for (genvar i = 0; i < 2; i++) begin : g_chk
        AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
            $rose(granted[i]) |-> $past(lock_req[i])); // R2
        AST_GRANT_EVT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
            grant_evt[i] |-> (granted[i] && !$past(granted[i]))); // R2
        AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
            (granted[i] && !lock_req[i]) |=> (!granted[i] && !lost_evt[i])); // R6
        AST_LOST_AFTER_OWN: assert property (@(posedge clk) disable iff (rst)
            lost_evt[i] |-> ($past(granted[i]) && !granted[i])); // R8
        AST_SWITCH_GATED: assert property (@(posedge clk) disable iff (rst)
            switch_en[i] |-> (granted[i] && connect[i])); // R5
    end
endmodule

bind dual_bus_lock_arbiter dual_bus_lock_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .lock_req  (lock_req),
    .connect   (connect),
    .granted   (granted),
    .switch_en (switch_en),
    .grant_evt (grant_evt),
    .lost_evt  (lost_evt)
);

// File: tb/dual_bus_lock_arbiter_tb_top.sv
module dual_bus_lock_arbiter_tb_top;
    localparam int RES_W   = 8;
    localparam int IDLE_MS = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ms_tick = 1'b0;
    logic               bus_active = 1'b0;
    logic [1:0]         lock_req = 2'b00;
    logic [1:0]         connect = 2'b00;
    logic [1:0]         prio = 2'b00;
    logic [1:0]         idle_en = 2'b00;
    logic [1:0]         rsv_wr = 2'b00;
    logic [2*RES_W-1:0] rsv_wdata = '0;
    logic [1:0]         granted, peer_locked, switch_en, grant_evt, lost_evt;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dual_bus_lock_arbiter #(.RES_W(RES_W), .IDLE_MS(IDLE_MS)) dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_active(bus_active),
        .lock_req(lock_req), .connect(connect), .prio(prio), .idle_en(idle_en),
        .rsv_wr(rsv_wr), .rsv_wdata(rsv_wdata), .granted(granted),
        .peer_locked(peer_locked), .switch_en(switch_en),
        .grant_evt(grant_evt), .lost_evt(lost_evt)
    );

    task automatic chk(input string r, input logic [1:0] a, input logic [1:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", r, a, e);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            step(1);
            ms_tick = 1'b0;
        end
    endtask

    task automatic write_rsv(input logic [1:0] sel, input logic [7:0] v0, input logic [7:0] v1);
        rsv_wr = sel;
        rsv_wdata = {v1, v0};
        step(1);
        rsv_wr = 2'b00;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 granted", granted, 2'b00);
        chk("R1 switch", switch_en, 2'b00);
        chk("R1 peer", peer_locked, 2'b00);
        chk("R1 events", grant_evt | lost_evt, 2'b00);

        // R2 lone request, reserve 10 on both so no preemption here
        write_rsv(2'b11, 8'd10, 8'd10);
        lock_req = 2'b01;
        step(1);
        chk("R2 grant m0", granted, 2'b01);
        chk("R2 grant_evt", grant_evt, 2'b01);
        chk("R3 peer flags", peer_locked, 2'b10);
        chk("R5 connect off", switch_en, 2'b00);
        connect = 2'b11;
        #1;
        chk("R5 connect on", switch_en, 2'b01);
        step(1);
        chk("R2 evt one cycle", grant_evt, 2'b00);
        lock_req = 2'b00;
        step(1);
        chk("R6 release", granted, 2'b00);
        chk("R6 no lost", lost_evt, 2'b00);
        chk("R5 open after release", switch_en, 2'b00);

        // R4 priority sweep
        for (int p = 0; p < 4; p++) begin
            logic [1:0] pv;
            logic [1:0] exp_g;
            pv = 2'(p);
            prio = pv;
            lock_req = 2'b11;
            step(1);
            exp_g = (pv[1] & ~pv[0]) ? 2'b10 : 2'b01;
            chk("R4 winner", granted, exp_g);
            chk("R4 grant_evt", grant_evt, exp_g);
            chk("R3 peer", peer_locked, {exp_g[0], exp_g[1]});
            lock_req = 2'b00;
            step(2);
        end
        prio = 2'b00;

        // R8 reservation countdown
        write_rsv(2'b01, 8'd3, 8'd0);
        lock_req = 2'b01;
        step(1);
        lock_req = 2'b11;
        step(1);
        chk("R8 waits", granted, 2'b01);
        tick(2);
        step(2);
        chk("R8 waits 2 ticks", granted, 2'b01);
        tick(1);
        chk("R8 not yet", granted, 2'b01);
        step(1);
        chk("R8 preempt", granted, 2'b10);
        chk("R8 lost_evt", lost_evt, 2'b01);
        chk("R8 grant_evt", grant_evt, 2'b10);
        lock_req = 2'b00;
        step(2);

        // R7 write ignored while granted
        write_rsv(2'b01, 8'd2, 8'd0);
        lock_req = 2'b01;
        step(1);
        write_rsv(2'b01, 8'd0, 8'd0);
        lock_req = 2'b00;
        step(1);
        lock_req = 2'b01;
        step(1);
        chk("R7 regrant", granted, 2'b01);
        lock_req = 2'b11;
        step(1);
        chk("R7 write ignored", granted, 2'b01);
        tick(1);
        step(1);
        chk("R7 still held", granted, 2'b01);
        lock_req = 2'b10;
        step(1);
        chk("R6 drop with waiter", granted, 2'b00);
        chk("R6 no lost waiter", lost_evt, 2'b00);
        step(1);
        chk("R6 waiter granted", granted, 2'b10);
        lock_req = 2'b00;
        step(2);

        // R9 zero reservation
        write_rsv(2'b11, 8'd0, 8'd10);
        lock_req = 2'b01;
        step(1);
        lock_req = 2'b11;
        step(1);
        chk("R9 immediate preempt", granted, 2'b10);
        chk("R9 lost_evt", lost_evt, 2'b01);
        lock_req = 2'b00;
        step(2);

        // R10 idle revocation
        idle_en = 2'b01;
        lock_req = 2'b01;
        step(1);
        tick(IDLE_MS);
        chk("R10 below limit", granted, 2'b01);
        tick(1);
        chk("R10 at limit", granted, 2'b01);
        step(1);
        chk("R10 revoked", granted, 2'b00);
        chk("R10 lost_evt", lost_evt, 2'b01);
        lock_req = 2'b00;
        step(2);
        lock_req = 2'b01;
        step(1);
        tick(IDLE_MS);
        bus_active = 1'b1;
        step(1);
        bus_active = 1'b0;
        tick(IDLE_MS);
        step(1);
        chk("R10 activity restarts", granted, 2'b01);
        lock_req = 2'b00;
        step(2);
        idle_en = 2'b00;
        lock_req = 2'b01;
        step(1);
        tick(3 * IDLE_MS);
        step(2);
        chk("R10 disabled", granted, 2'b01);
        chk("R10 disabled no lost", lost_evt, 2'b00);
        lock_req = 2'b00;
        step(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule